// File: doc/BRIEF.md
# Append-Only Wiper Store Sequencer

This block sequences a small one-time-programmable store that keeps the wiper setting a rheostat uses at power-up. A program request carries a 10-bit wiper value. The block writes that value into the next unused word of a 50-word append-only array. Words are numbered from 1, so the first commit lands in word 1 and each later commit lands in the word after it. While a commit is in progress the block raises a busy lock for a parameterised number of clock cycles. When the lock drops, a status bit reports whether the commit succeeded.

The block also supplies the wiper value. Reset presents mid-scale. A refresh request reloads the wiper output from the most recently committed word, or gives mid-scale if no word has been used yet. Once all 50 words are used, a further program request fails in a single cycle. It writes nothing and clears the status bit. The array is a behavioural register file held inside the block. A count of used words is exported for the surrounding logic.

Top module: `otp_wiper_seq`

## Requirements
- R1: After reset, `busy` is 0, `prog_ok` is 0, `used_count` is 0 and `wiper` is 10'h200 (mid-scale).
- R2: A program request sampled while `busy` is 0 and fewer than 50 words are used raises `busy` at that clock edge. `busy` then stays high for exactly `PROG_CYCLES` cycles.
- R3: At the edge where `busy` falls after an accepted request, `used_count` rises by exactly one and `prog_ok` becomes 1. `prog_ok` reads 0 while the commit is in progress.
- R4: Commits go to consecutive words starting at word 1. A refresh taken after one or more commits sets `wiper` to the value of the latest commit, one cycle after the request.
- R5: A refresh taken while no word is used sets `wiper` to 10'h200.
- R6: Program and refresh requests sampled while `busy` is 1 are ignored. `used_count`, `wiper` and the remaining length of the busy window are all left unchanged.
- R7: With all 50 words used, a program request leaves `busy` at 0 and `used_count` at 50. It clears `prog_ok` one cycle after the request. A following refresh still returns the value committed last.
- R8: `wiper` changes only on reset or on an accepted refresh. A commit alone does not alter it.
- R9: `used_count` never exceeds 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| prog_req | input | 1 | Request to commit `prog_data` to the next free word |
| prog_data | input | 10 | Wiper value to commit |
| refresh_req | input | 1 | Reload `wiper` from the store |
| busy | output | 1 | Commit in progress; requests are locked out |
| prog_ok | output | 1 | Result of the last program request (1 = committed) |
| wiper | output | 10 | Wiper value presented to the rheostat |
| used_count | output | 6 | Number of words used, 0 to 50 |

## Verification
Each request is driven on a falling edge and sampled by the design on the following rising edge. A refresh result is read at the next falling edge. For an accepted commit, `busy` is checked on every one of the `PROG_CYCLES` falling edges that follow the request. `prog_ok` and `used_count` are checked at the first falling edge after `busy` drops. A rejected request on a full store is checked one falling edge after it is raised. Lockout is tested by raising both requests on the second falling edge of the busy window. The checks then confirm that the window length, the count and the wiper value did not move. Random commit, refresh and idle operations from a fixed seed are compared against a model of the word list kept in the bench. Directed steps cover the empty store, the first word and the full store.

// File: rtl/otp_wiper_seq.sv
module otp_wiper_seq #(
  parameter  int WORDS       = 50,
  parameter  int DW          = 10,
  parameter  int PROG_CYCLES = 20,
  localparam int CW          = $clog2(WORDS + 1),
  localparam int TW          = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_req,
  input  logic [DW-1:0] prog_data,
  input  logic          refresh_req,
  output logic          busy,
  output logic          prog_ok,
  output logic [DW-1:0] wiper,
  output logic [CW-1:0] used_count
);

  localparam logic [DW-1:0] MID  = DW'(1) << (DW - 1);
  localparam logic [CW-1:0] FULL = CW'(WORDS);

  logic [DW-1:0] mem [1:WORDS];
  logic [DW-1:0] pend;
  logic [TW-1:0] cnt;
  logic [CW-1:0] used;

  wire accept = prog_req && !busy && (used < FULL);
  wire reject = prog_req && !busy && (used == FULL);
  wire done   = busy && (cnt == '0);
  wire reload = refresh_req && !busy;

  assign used_count = used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      used    <= '0;
      prog_ok <= 1'b0;
      pend    <= '0;
      wiper   <= MID;
    end else begin
      if (accept) begin
        busy    <= 1'b1;
        cnt     <= TW'(PROG_CYCLES - 1);
        pend    <= prog_data;
        prog_ok <= 1'b0;
      end else if (reject) begin
        prog_ok <= 1'b0;
      end
      if (done) begin
        busy    <= 1'b0;
        used    <= used + CW'(1);
        prog_ok <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - TW'(1);
      end
      if (reload)
        wiper <= (used == '0) ? MID : mem[used];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && done)
      mem[used + CW'(1)] <= pend;
  end

  // R9
  used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_count <= FULL);

  // R3
  commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (used_count == $past(used_count) + CW'(1)) && prog_ok);

  // R6
  locked_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || (used_count == $past(used_count) + CW'(1)));

  // R7
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !busy && used_count == FULL) |=> !busy && !prog_ok && $stable(used_count));

  // R8
  wiper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(refresh_req && !busy) |=> $stable(wiper));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !busy && used_count < FULL) |=> busy && !prog_ok);

endmodule

// File: tb/otp_wiper_seq_tb.sv
module otp_wiper_seq_tb;
  localparam int PC    = 6;
  localparam int WORDS = 50;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       prog_req = 0;
  logic [9:0] prog_data = '0;
  logic       refresh_req = 0;
  logic       busy, prog_ok;
  logic [9:0] wiper;
  logic [5:0] used_count;

  int checks = 0, errors = 0;
  logic [9:0] model_mem [0:WORDS];
  int   m_used = 0;
  logic [9:0] m_wiper = 10'h200;

  otp_wiper_seq #(.WORDS(WORDS), .DW(10), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_data(prog_data),
    .refresh_req(refresh_req), .busy(busy), .prog_ok(prog_ok),
    .wiper(wiper), .used_count(used_count));

  always #10 clk = ~clk;

  function automatic logic [9:0] restore_val();
    return (m_used == 0) ? 10'h200 : model_mem[m_used];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_refresh();
    @(negedge clk); refresh_req = 1;
    @(negedge clk); refresh_req = 0;
    m_wiper = restore_val();
    chk(m_used == 0 ? "R5 refresh empty" : "R4 refresh last", wiper, m_wiper);
  endtask

  task automatic do_prog(input logic [9:0] d, input bit poke);
    @(negedge clk); prog_req = 1; prog_data = d;
    if (m_used == WORDS) begin
      @(negedge clk); prog_req = 0;
      chk("R7 full busy", busy, 0);
      chk("R7 full status", prog_ok, 0);
      chk("R7 full count", used_count, WORDS);
      return;
    end
    @(negedge clk); prog_req = 0;
    chk("R2 busy rise", busy, 1);
    chk("R3 status during", prog_ok, 0);
    for (int k = 2; k <= PC; k++) begin
      @(negedge clk);
      if (k == 3) begin prog_req = 0; refresh_req = 0; end
      chk("R2 busy hold", busy, 1);
      if (poke && k == 2) begin
        prog_req = 1; prog_data = ~d; refresh_req = 1;
      end
    end
    prog_req = 0; refresh_req = 0;
    @(negedge clk);
    m_used++;
    model_mem[m_used] = d;
    chk("R2 busy fall", busy, 0);
    chk("R3 status ok", prog_ok, 1);
    chk("R3 R6 count", used_count, m_used);
    chk("R8 wiper unchanged", wiper, m_wiper);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 status", prog_ok, 0);
    chk("R1 count", used_count, 0);
    chk("R1 wiper", wiper, 10'h200);
    do_refresh();
    do_prog(10'h155, 1);
    chk("R4 first word", used_count, 1);
    do_refresh();
    for (int i = 0; i < 90; i++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) do_refresh();
      else if (op == 1) repeat ($urandom_range(1, 3)) @(negedge clk);
      else do_prog(10'($urandom), $urandom_range(0, 1) == 1);
    end
    while (m_used < WORDS) do_prog(10'($urandom), 0);
    do_prog(10'h3ff, 0);
    do_prog(10'h001, 0);
    do_refresh();
    chk("R9 count cap", used_count, WORDS);
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_used = 0; m_wiper = 10'h200;
    @(negedge clk);
    chk("R1 wiper after reset", wiper, 10'h200);
    chk("R1 count after reset", used_count, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule